// File: doc/BRIEF.md
# Bank Address Demultiplexer

A processor with a 16-bit address bus and an 8-bit data bus can reach a 24-bit space by placing the upper address byte (the bank) on its data pins during the low half of the phase-2 clock. In the high half, the same pins carry ordinary read or write data. This block separates the two uses of those pins.

The block captures the bank byte while phase-2 is low and at least one valid-address qualifier is asserted. It joins the bank byte to the 16 direct address lines to form a full address. It also gives downstream logic a data byte that can never contain a bank number. The whole block runs on a fast system clock, and phase-2 and the bus pins are sampled as ordinary inputs.

The stored bank byte updates on every system clock edge that falls inside a qualified low phase. It stays frozen while phase-2 is high. A combinational bypass shows the live bank byte during a qualified low phase. As a result, the full address is already correct before the first edge of that phase.

Top module: `bank_addr_demux`

## Requirements
- R1: Reset (`rst` high, asynchronous) clears the stored bank to 0x00. After reset, with phase-2 high, `addrFull[23:16]` reads 0x00.
- R2: While `phi2` is 0 and `vda` or `vpa` is 1, `addrFull[23:16]` equals `dataBus` in the same cycle.
- R3: While `phi2` is 1, `addrFull[23:16]` equals the `dataBus` value at the last rising clock edge that saw `phi2`=0 with a qualifier set. Changes on `dataBus` in the high phase do not alter it.
- R4: `addrFull[15:0]` always equals `addrLo`. `addrFull` is the plain concatenation {bank, addrLo}, with no carry between the two parts (bank 0xFF with addrLo 0xFFFF gives 0xFFFFFF).
- R5: `addrValid` equals `vda | vpa` in the same cycle.
- R6: While `phi2` is 0 and both `vda` and `vpa` are 0, the bank is not captured. `addrFull[23:16]` shows the stored bank, and the stored bank is unchanged afterwards.
- R7: `dataOut` equals `dataBus` while `phi2` is 1, and equals 0x00 while `phi2` is 0.
- R8: Across consecutive cycles with `phi2` high, `addrFull[23:16]` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bus |
| rst | input | 1 | Asynchronous reset, active high |
| phi2 | input | 1 | Processor phase-2 clock level |
| vda | input | 1 | Valid data-address qualifier |
| vpa | input | 1 | Valid program-address qualifier |
| dataBus | input | 8 | Shared bank/data pins |
| addrLo | input | 16 | Direct low address lines |
| addrFull | output | 24 | Rebuilt address {bank, addrLo} |
| addrValid | output | 1 | Either qualifier asserted |
| dataOut | output | 8 | Data byte, zero during phase-2 low |

## Verification
The bench builds the block with its default parameters: a 16-bit low address, an 8-bit bank and the bypass enabled. With these values, the all-ones bank and low-address pattern exercises the no-carry rule. The 8-bit data bus lets random bytes cover every bank value.

Random bus cycles of one to three clocks per phase mix qualified and unqualified low phases with changing high-phase data. Each of these cycles is compared against a bench model of the stored bank. A reset in the middle of the run, taken while a nonzero bank is held, shows that the stored bank clears.

// File: rtl/bank_demux_pkg.sv
package bank_demux_pkg;
  typedef struct packed {
    logic captureEn;
    logic bypassSel;
    logic dataPass;
    logic addrValid;
  } demuxStrobe_t;
endpackage

// File: rtl/bank_demux_ctrl.sv
module bank_demux_ctrl
  import bank_demux_pkg::*;
(
  input  logic         phi2,
  input  logic         vda,
  input  logic         vpa,
  output demuxStrobe_t strobe
);
  logic lowPhase;
  logic anyQual;

  always_comb begin
    lowPhase         = ~phi2;
    anyQual          = vda | vpa;
    // capture and bypass only in a qualified low phase
    strobe.captureEn = lowPhase & anyQual;
    strobe.bypassSel = lowPhase & anyQual;
    strobe.dataPass  = phi2;
    strobe.addrValid = anyQual;
  end
endmodule

// File: rtl/bank_demux_dp.sv
module bank_demux_dp
  import bank_demux_pkg::*;
#(
  parameter int LO_W       = 16,
  parameter int BANK_W     = 8,
  parameter int RESET_BANK = 0,
  parameter bit BYPASS_EN  = 1'b1,
  localparam int ADDR_W    = LO_W + BANK_W
) (
  input  logic              clk,
  input  logic              rst,
  input  demuxStrobe_t      strobe,
  input  logic [BANK_W-1:0] dataIn,
  input  logic [LO_W-1:0]   addrLo,
  output logic [ADDR_W-1:0] addrOut,
  output logic [BANK_W-1:0] dataOut
);
  logic [BANK_W-1:0] heldBank;
  logic [BANK_W-1:0] bankSel;

  always_ff @(posedge clk or posedge rst) begin
    if (rst)                   heldBank <= BANK_W'(RESET_BANK);
    else if (strobe.captureEn) heldBank <= dataIn;
  end

  generate
    if (BYPASS_EN) begin : g_bypass
      always_comb bankSel = strobe.bypassSel ? dataIn : heldBank;
    end else begin : g_regonly
      logic unusedBypass;
      always_comb begin
        unusedBypass = strobe.bypassSel;
        bankSel      = heldBank;
      end
    end
  endgenerate

  always_comb begin
    addrOut = {bankSel, addrLo};
    dataOut = strobe.dataPass ? dataIn : '0;
  end
endmodule

// File: rtl/bank_addr_demux.sv
module bank_addr_demux
  import bank_demux_pkg::*;
#(
  parameter int LO_W       = 16,
  parameter int BANK_W     = 8,
  parameter int RESET_BANK = 0,
  parameter bit BYPASS_EN  = 1'b1,
  localparam int ADDR_W    = LO_W + BANK_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              phi2,
  input  logic              vda,
  input  logic              vpa,
  input  logic [BANK_W-1:0] dataBus,
  input  logic [LO_W-1:0]   addrLo,
  output logic [ADDR_W-1:0] addrFull,
  output logic              addrValid,
  output logic [BANK_W-1:0] dataOut
);
  demuxStrobe_t strobe;

  bank_demux_ctrl ctrl_i (
    .phi2   (phi2),
    .vda    (vda),
    .vpa    (vpa),
    .strobe (strobe)
  );

  bank_demux_dp #(
    .LO_W       (LO_W),
    .BANK_W     (BANK_W),
    .RESET_BANK (RESET_BANK),
    .BYPASS_EN  (BYPASS_EN)
  ) dp_i (
    .clk     (clk),
    .rst     (rst),
    .strobe  (strobe),
    .dataIn  (dataBus),
    .addrLo  (addrLo),
    .addrOut (addrFull),
    .dataOut (dataOut)
  );

  assign addrValid = strobe.addrValid;
endmodule

// File: rtl/bank_demux_chk.sv
module bank_demux_chk #(
  parameter int LO_W   = 16,
  parameter int BANK_W = 8,
  localparam int ADDR_W = LO_W + BANK_W
) (
  input logic              clk,
  input logic              rst,
  input logic              phi2,
  input logic              vda,
  input logic              vpa,
  input logic [BANK_W-1:0] dataBus,
  input logic [LO_W-1:0]   addrLo,
  input logic [ADDR_W-1:0] addrFull,
  input logic              addrValid,
  input logic [BANK_W-1:0] dataOut
);
  logic [BANK_W-1:0] bankOut;
  assign bankOut = addrFull[ADDR_W-1 -: BANK_W];

  p_transparent_r2: assert property (@(posedge clk) disable iff (rst)
    (!phi2 && (vda || vpa)) |-> bankOut == dataBus);

  p_low_pass_r4: assert property (@(posedge clk) disable iff (rst)
    addrFull[LO_W-1:0] == addrLo);

  p_valid_r5: assert property (@(posedge clk) disable iff (rst)
    addrValid == (vda | vpa));

  p_no_capture_r6: assert property (@(posedge clk) disable iff (rst)
    (!phi2 && !vda && !vpa && $past(phi2 || !(vda || vpa))) |-> $stable(bankOut));

  p_data_gate_r7: assert property (@(posedge clk) disable iff (rst)
    !phi2 |-> dataOut == '0);

  p_bank_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (phi2 && $past(phi2)) |-> $stable(bankOut));
endmodule

bind bank_addr_demux bank_demux_chk #(.LO_W(LO_W), .BANK_W(BANK_W)) chk_i (
  .clk(clk), .rst(rst), .phi2(phi2), .vda(vda), .vpa(vpa),
  .dataBus(dataBus), .addrLo(addrLo), .addrFull(addrFull),
  .addrValid(addrValid), .dataOut(dataOut)
);

// File: tb/bank_addr_demux_tb_top.sv
`timescale 1ns/1ps
module bank_addr_demux_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        phi2 = 1'b1;
  logic        vda = 1'b0;
  logic        vpa = 1'b0;
  logic [7:0]  dataBus = 8'h00;
  logic [15:0] addrLo = 16'h0000;
  logic [23:0] addrFull;
  logic        addrValid;
  logic [7:0]  dataOut;

  int checks = 0;
  int failures = 0;
  logic [7:0] heldModel = 8'h00;
  logic       prevHigh = 1'b0;
  logic [7:0] prevBank = 8'h00;

  always #5 clk = ~clk;

  bank_addr_demux dut_i (
    .clk(clk), .rst(rst), .phi2(phi2), .vda(vda), .vpa(vpa),
    .dataBus(dataBus), .addrLo(addrLo), .addrFull(addrFull),
    .addrValid(addrValid), .dataOut(dataOut)
  );

  function automatic logic [7:0] expBank(input logic p, input logic q, input logic [7:0] d);
    return (!p && q) ? d : heldModel;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic p, input logic a, input logic b,
                       input logic [7:0] d, input logic [15:0] lo);
    logic [7:0] eb;
    @(negedge clk);
    phi2 = p; vda = a; vpa = b; dataBus = d; addrLo = lo;
    #1;
    eb = expBank(p, a | b, d);
    if (!p && (a | b)) chk(addrFull[23:16] == eb, "R2 transparent bank", 32'(addrFull[23:16]), 32'(eb));
    else if (p)        chk(addrFull[23:16] == eb, "R3 held bank", 32'(addrFull[23:16]), 32'(eb));
    else               chk(addrFull[23:16] == eb, "R6 unqualified low", 32'(addrFull[23:16]), 32'(eb));
    chk(addrFull == {eb, lo}, "R4 concatenation", 32'(addrFull), 32'({eb, lo}));
    chk(addrValid == (a | b), "R5 valid flag", 32'(addrValid), 32'(a | b));
    chk(dataOut == (p ? d : 8'h00), "R7 data gate", 32'(dataOut), 32'(p ? d : 8'h00));
    if (p && prevHigh) chk(addrFull[23:16] == prevBank, "R8 high-phase stability", 32'(addrFull[23:16]), 32'(prevBank));
    prevHigh = p;
    prevBank = addrFull[23:16];
    if (!p && (a | b)) heldModel = d;
  endtask

  initial begin
    #2_000_000;
    failures++;
    checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int unsigned seedDummy;
    seedDummy = $urandom(32'd4242);
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0; addrLo = 16'h1357;
    #1;
    // R1: bank cleared by reset
    chk(addrFull == 24'h001357, "R1 reset bank", 32'(addrFull), 32'h001357);
    heldModel = 8'h00;

    // directed: bank 0x12, address 0xAB34
    drive(1'b0, 1'b1, 1'b0, 8'h12, 16'hAB34);
    drive(1'b1, 1'b1, 1'b0, 8'h99, 16'hAB34);
    drive(1'b1, 1'b1, 1'b0, 8'h5A, 16'hAB34);
    // R4 corner: all ones, no carry
    drive(1'b0, 1'b0, 1'b1, 8'hFF, 16'hFFFF);
    drive(1'b1, 1'b0, 1'b1, 8'h01, 16'hFFFF);
    // R6: unqualified low keeps 0xFF
    drive(1'b0, 1'b0, 1'b0, 8'h33, 16'h0000);
    drive(1'b0, 1'b0, 1'b0, 8'h44, 16'h0001);
    drive(1'b1, 1'b0, 1'b0, 8'h55, 16'h0002);

    // random bus cycles
    for (int i = 0; i < 400; i++) begin
      logic a, b;
      logic [15:0] lo;
      a = 1'($urandom);
      b = 1'($urandom % 3 == 0);
      lo = 16'($urandom);
      for (int j = 0; j < 1 + int'($urandom % 3); j++) drive(1'b0, a, b, 8'($urandom), lo);
      for (int j = 0; j < 1 + int'($urandom % 3); j++) drive(1'b1, a, b, 8'($urandom), lo);
    end

    // R1: mid-run reset while a nonzero bank is held
    drive(1'b0, 1'b1, 1'b1, 8'hC3, 16'h2222);
    drive(1'b1, 1'b1, 1'b1, 8'h00, 16'h2222);
    @(negedge clk); rst = 1'b1; #1;
    chk(addrFull[23:16] == 8'h00, "R1 reset mid-run", 32'(addrFull[23:16]), 32'h0);
    @(negedge clk); rst = 1'b0;
    heldModel = 8'h00;
    prevHigh = 1'b0;
    drive(1'b1, 1'b0, 1'b0, 8'h77, 16'h3333);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule